// File: doc/BRIEF.md
# Dual-Mode Dead-Time Generator

This block turns the stream of trigger accepts into veto signals that keep downstream event buffers from overflowing. It runs on the bunch-crossing clock, one cycle per 25 ns crossing. A single accept input marks each cycle in which an accept was issued. Two kinds of protection act on that stream.

The first is a fixed hold-off. After every accept, further accepts are forbidden for a programmable number of crossings. The second is a pair of leaky-bucket rate limiters, one serving high-priority items and one serving low-priority items. Each bucket fills by one per accept and drains by one every programmable drain period. Its class veto is raised while the bucket holds its programmed capacity, which caps the burst size and the long-term rate of that class.

The hold-off veto is also folded into both class vetoes, so the logic that gates the items only needs the class veto for each priority. Typical programming is a hold-off of 4, a capacity of 8 and a drain period of 400 crossings. That setting allows 8 accepts per 3200 crossings.

Top module: `dead_time_gen`

## Requirements
- R1: While reset is asserted and on the first cycles after it is released, all three vetoes are low and both buckets are empty.
- R2: An accept with hold-off length N>0 raises `simple_veto_o` for exactly the N cycles after the accept edge. An accept that arrives while the veto is active reloads the count to N. Without an accept, the veto never rises.
- R3: With hold-off length 0, `simple_veto_o` stays low whatever the accepts.
- R4: Whenever `simple_veto_o` is high, both `veto_hi_o` and `veto_lo_o` are high.
- R5: Each accept raises both bucket fill levels by one, saturating at the capacity. A class veto is high while its fill level is at least its nonzero capacity.
- R6: Each bucket has a free-running drain counter with period P>0. A drain tick occurs on every P-th cycle after the bucket was last cleared. A tick lowers the fill level by one unless the level is already zero. P=0 disables draining.
- R7: An accept on the same cycle as a drain tick of a non-empty bucket leaves that bucket's fill level unchanged.
- R8: A capacity of 0 disables that class's bucket veto; only the hold-off can then veto that class.
- R9: A change of a bucket's capacity or drain period clears that bucket's fill level and restarts its drain counter on the next edge.
- R10: The two buckets are independent: the capacity and period of one have no effect on the veto of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | An accept was issued this crossing |
| hold_len_i | input | HOLD_W | Hold-off length in crossings |
| cap_hi_i | input | CAP_W | High-priority bucket capacity |
| drain_hi_i | input | PER_W | High-priority drain period in crossings |
| cap_lo_i | input | CAP_W | Low-priority bucket capacity |
| drain_lo_i | input | PER_W | Low-priority drain period in crossings |
| simple_veto_o | output | 1 | Hold-off veto |
| veto_hi_o | output | 1 | Veto for high-priority items |
| veto_lo_o | output | 1 | Veto for low-priority items |

## Verification
The bench sweeps small hold-off lengths, capacities and drain periods, including the zero values, under three accept densities. Every output is compared on every cycle against an arithmetic model. Accepts that land on a drain tick catch a design that lets the tick win or adds both, because the fill level would drift by one and the veto would open or close a cycle early. Each new configuration changes a bucket's settings in mid-run. A design that keeps the old fill level, or does not restart the drain phase, would then veto on the wrong cycles. Hold-off lengths of 0 and 1, together with back-to-back accepts, expose an off-by-one count or a missing reload.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int NUM_CLS = 2;
  localparam int CLS_HI  = 0;
  localparam int CLS_LO  = 1;
endpackage

// File: rtl/dt_holdoff.sv
module dt_holdoff #(
  parameter int HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [HOLD_W-1:0] hold_len_i,
  output logic              veto_o
);
  logic [HOLD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (accept_i)            cnt_d = hold_len_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - HOLD_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign veto_o = (cnt_q != '0);
endmodule

// File: rtl/dt_cfg_watch.sv
module dt_cfg_watch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cfg_i,
  output logic         changed_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cfg_i;
  end

  assign changed_o = (cfg_i != prev_q);
endmodule

// File: rtl/dt_bucket.sv
module dt_bucket #(
  parameter int CAP_W = 8,
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [CAP_W-1:0] cap_i,
  input  logic [PER_W-1:0] period_i,
  output logic [CAP_W-1:0] fill_o,
  output logic             full_o
);
  localparam int CFG_W = CAP_W + PER_W;

  logic [CAP_W-1:0] fill_q, fill_d;
  logic [PER_W-1:0] dcnt_q, dcnt_d;
  logic             tick, dec, clr;

  dt_cfg_watch #(.W(CFG_W)) u_watch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    ({cap_i, period_i}),
    .changed_o(clr)
  );

  always_comb begin
    tick   = (period_i != '0) && (dcnt_q == period_i - PER_W'(1));
    dec    = tick && (fill_q != '0);
    dcnt_d = (tick || period_i == '0) ? '0 : dcnt_q + PER_W'(1);
    fill_d = fill_q;
    // accept and drain on one cycle cancel
    if (accept_i && !dec) begin
      if (fill_q < cap_i) fill_d = fill_q + CAP_W'(1);
    end else if (dec && !accept_i) begin
      fill_d = fill_q - CAP_W'(1);
    end
    if (clr) begin
      fill_d = '0;
      dcnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      dcnt_q <= '0;
    end else begin
      fill_q <= fill_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign fill_o = fill_q;
  assign full_o = (cap_i != '0) && (fill_q >= cap_i);
endmodule

// File: rtl/dead_time_gen.sv
module dead_time_gen
  import dt_pkg::*;
#(
  parameter int HOLD_W = 8,
  parameter int CAP_W  = 8,
  parameter int PER_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [HOLD_W-1:0] hold_len_i,
  input  logic [CAP_W-1:0]  cap_hi_i,
  input  logic [PER_W-1:0]  drain_hi_i,
  input  logic [CAP_W-1:0]  cap_lo_i,
  input  logic [PER_W-1:0]  drain_lo_i,
  output logic              simple_veto_o,
  output logic              veto_hi_o,
  output logic              veto_lo_o
);
  logic [CAP_W-1:0] cap   [NUM_CLS];
  logic [PER_W-1:0] per   [NUM_CLS];
  logic [CAP_W-1:0] fill  [NUM_CLS];
  logic             full  [NUM_CLS];
  logic [CAP_W-1:0] fill_hi, fill_lo;
  logic             hold_veto;

  assign cap[CLS_HI] = cap_hi_i;
  assign cap[CLS_LO] = cap_lo_i;
  assign per[CLS_HI] = drain_hi_i;
  assign per[CLS_LO] = drain_lo_i;

  dt_holdoff #(.HOLD_W(HOLD_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept_i),
    .hold_len_i(hold_len_i),
    .veto_o    (hold_veto)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    dt_bucket #(.CAP_W(CAP_W), .PER_W(PER_W)) u_bkt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .accept_i(accept_i),
      .cap_i   (cap[c]),
      .period_i(per[c]),
      .fill_o  (fill[c]),
      .full_o  (full[c])
    );
  end

  assign fill_hi       = fill[CLS_HI];
  assign fill_lo       = fill[CLS_LO];
  assign simple_veto_o = hold_veto;
  assign veto_hi_o     = hold_veto | full[CLS_HI];
  assign veto_lo_o     = hold_veto | full[CLS_LO];
endmodule

// File: rtl/dead_time_gen_chk.sv
module dead_time_gen_chk #(
  parameter int HOLD_W = 8,
  parameter int CAP_W  = 8,
  parameter int PER_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              accept_i,
  input logic [HOLD_W-1:0] hold_len_i,
  input logic [CAP_W-1:0]  cap_hi_i,
  input logic [PER_W-1:0]  drain_hi_i,
  input logic [CAP_W-1:0]  cap_lo_i,
  input logic              simple_veto_o,
  input logic              veto_hi_o,
  input logic              veto_lo_o,
  input logic [CAP_W-1:0]  fill_hi,
  input logic [CAP_W-1:0]  fill_lo
);
  assert_hold_arms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && hold_len_i != '0) |=> simple_veto_o);

  assert_no_spurious_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept_i && !simple_veto_o) |=> !simple_veto_o);

  assert_hold_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_len_i == '0 && $stable(hold_len_i) && !simple_veto_o) |=> !simple_veto_o);

  assert_hold_spans_classes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    simple_veto_o |-> (veto_hi_o && veto_lo_o));

  assert_fill_step_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fill_hi == $past(fill_hi) || fill_hi == $past(fill_hi) + 1'b1 ||
              fill_hi == $past(fill_hi) - 1'b1 || fill_hi == '0));

  assert_fill_step_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fill_lo == $past(fill_lo) || fill_lo == $past(fill_lo) + 1'b1 ||
              fill_lo == $past(fill_lo) - 1'b1 || fill_lo == '0));

  assert_cap_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_lo_i == '0 && !simple_veto_o) |-> !veto_lo_o);

  assert_cfg_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_hi_i != $past(cap_hi_i) || drain_hi_i != $past(drain_hi_i)) |=> fill_hi == '0);
endmodule

bind dead_time_gen dead_time_gen_chk #(.HOLD_W(HOLD_W), .CAP_W(CAP_W), .PER_W(PER_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .accept_i     (accept_i),
  .hold_len_i   (hold_len_i),
  .cap_hi_i     (cap_hi_i),
  .drain_hi_i   (drain_hi_i),
  .cap_lo_i     (cap_lo_i),
  .simple_veto_o(simple_veto_o),
  .veto_hi_o    (veto_hi_o),
  .veto_lo_o    (veto_lo_o),
  .fill_hi      (fill_hi),
  .fill_lo      (fill_lo)
);

// File: tb/dead_time_gen_tb_top.sv
module dead_time_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_W = 8;
  localparam int CAP_W  = 8;
  localparam int PER_W  = 16;
  localparam int RUN_LEN = 30;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              accept_i = 1'b0;
  logic [HOLD_W-1:0] hold_len_i = '0;
  logic [CAP_W-1:0]  cap_hi_i = '0, cap_lo_i = '0;
  logic [PER_W-1:0]  drain_hi_i = '0, drain_lo_i = '0;
  logic              simple_veto_o, veto_hi_o, veto_lo_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // bench-side expected state
  int m_hold;
  int m_fill [2];
  int m_dcnt [2];
  int m_pcap [2];
  int m_pper [2];
  string m_tag [2];
  bit m_tick_acc [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dead_time_gen #(.HOLD_W(HOLD_W), .CAP_W(CAP_W), .PER_W(PER_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .accept_i(accept_i), .hold_len_i(hold_len_i),
    .cap_hi_i(cap_hi_i), .drain_hi_i(drain_hi_i), .cap_lo_i(cap_lo_i),
    .drain_lo_i(drain_lo_i), .simple_veto_o(simple_veto_o),
    .veto_hi_o(veto_hi_o), .veto_lo_o(veto_lo_o)
  );

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int cfg_cap(input int c);
    return (c == 0) ? int'(cap_hi_i) : int'(cap_lo_i);
  endfunction

  function automatic int cfg_per(input int c);
    return (c == 0) ? int'(drain_hi_i) : int'(drain_lo_i);
  endfunction

  task automatic model_reset();
    m_hold = 0;
    for (int c = 0; c < 2; c++) begin
      m_fill[c] = 0; m_dcnt[c] = 0; m_pcap[c] = 0; m_pper[c] = 0;
      m_tag[c] = "R5"; m_tick_acc[c] = 1'b0;
    end
  endtask

  // one edge of the requirement model, using the inputs held across it
  task automatic model_edge();
    bit acc;
    acc = accept_i;
    if (acc) m_hold = int'(hold_len_i);
    else if (m_hold > 0) m_hold--;
    for (int c = 0; c < 2; c++) begin
      int cap, per;
      bit tick, dec;
      cap = cfg_cap(c);
      per = cfg_per(c);
      if (cap != m_pcap[c] || per != m_pper[c]) begin
        m_fill[c] = 0; m_dcnt[c] = 0; m_tag[c] = "R9";
      end else begin
        tick = (per != 0) && (m_dcnt[c] == per - 1);
        dec  = tick && (m_fill[c] > 0);
        m_dcnt[c] = (tick || per == 0) ? 0 : m_dcnt[c] + 1;
        if (acc && dec) m_tag[c] = "R7";
        else if (dec) m_tag[c] = "R6";
        else m_tag[c] = "R5";
        if (acc && !dec) begin
          if (m_fill[c] < cap) m_fill[c]++;
        end else if (dec && !acc) m_fill[c]--;
      end
      m_pcap[c] = cap;
      m_pper[c] = per;
    end
  endtask

  task automatic compare_all();
    bit es, eb0, eb1;
    es  = (m_hold != 0);
    eb0 = (cfg_cap(0) != 0) && (m_fill[0] >= cfg_cap(0));
    eb1 = (cfg_cap(1) != 0) && (m_fill[1] >= cfg_cap(1));
    check(simple_veto_o, es, (hold_len_i == 0) ? "R3" : "R2", "simple veto");
    if (es) begin
      check(veto_hi_o, 1'b1, "R4", "hi veto under hold-off");
      check(veto_lo_o, 1'b1, "R4", "lo veto under hold-off");
    end else begin
      check(veto_hi_o, eb0, (cfg_cap(0) == 0) ? "R8" : m_tag[0], "hi veto");
      check(veto_lo_o, eb1,
            (cfg_cap(1) == 0) ? "R8" :
            ((cfg_cap(1) != cfg_cap(0) || cfg_per(1) != cfg_per(0)) ? "R10" : m_tag[1]),
            "lo veto");
    end
  endtask

  task automatic step(input bit acc);
    accept_i = acc;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(simple_veto_o, 1'b0, "R1", "simple veto in reset");
    check(veto_hi_o, 1'b0, "R1", "hi veto in reset");
    check(veto_lo_o, 1'b0, "R1", "lo veto in reset");
    hold_len_i = 8'd4; cap_hi_i = 8'd2; drain_hi_i = 16'd5;
    cap_lo_i = 8'd3; drain_lo_i = 16'd7;
    rst_ni = 1'b1;
    step(1'b0);
    check(veto_hi_o, 1'b0, "R1", "hi veto after reset");
    check(veto_lo_o, 1'b0, "R1", "lo veto after reset");

    // directed: hold-off of 4, back-to-back reload (R2)
    step(1'b1);
    for (int i = 0; i < 3; i++) step(1'b0);
    step(1'b1);
    for (int i = 0; i < 8; i++) step(1'b0);

    // sweep small configurations under three densities
    for (int dens = 0; dens < 3; dens++) begin
      for (int h = 0; h < 4; h++) begin
        for (int ch = 0; ch < 4; ch++) begin
          for (int ph = 0; ph < 4; ph++) begin
            hold_len_i = HOLD_W'(h);
            cap_hi_i   = CAP_W'(ch);
            drain_hi_i = PER_W'(ph);
            cap_lo_i   = CAP_W'((ch + 1) % 4);
            drain_lo_i = PER_W'((ph + dens + 2) % 5);
            for (int k = 0; k < RUN_LEN; k++) begin
              int thr;
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              thr = (dens == 0) ? 1 : ((dens == 1) ? 3 : 6);
              step(int'(lfsr[2:0]) < thr);
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule